// File: doc/BRIEF.md
# Multi-Cycle Load/Store Instruction Sequencer

This block is a small 32-bit processor core without a pipeline. Each instruction moves through up to five steps: fetch, decode with register read, execute or address calculation, memory access or branch completion, and register write-back. Between steps every intermediate value is held in its own register: the fetched word, the incremented PC, both source operands, the sign-extended immediate, the execute result, the loaded data and the branch condition. The number of cycles an instruction takes depends on its class. Loads, ALU operations and jump-and-link use all five steps. Stores, branches, plain jumps and unrecognised words finish after the memory step.

The core drives a word address to an instruction memory and expects the word back in the same cycle. It drives a word address, write data and separate read and write strobes to a data memory, and expects read data back in the same cycle. A one-cycle retire pulse marks the last cycle of every instruction. The pulse carries the number of cycles that instruction took, so that a test environment can follow the core's progress.

Top module: `seq_core`

## Requirements
- R1: While `rst_n` is low, `retire`, `dmem_we` and `dmem_re` are low. In the first cycle after reset is released, `imem_addr` is 0.
- R2: Opcode 0x00 selects a register-register operation. The fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. The funct codes are: 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than, 0x00 shift rt left by shamt, and 0x02 shift rt right logically by shamt. The result is written to rd, and the instruction takes 5 cycles.
- R3: The immediate operations are opcode 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor. Each combines rs with bits [15:0] sign-extended to 32 bits, writes the result to rt and takes 5 cycles.
- R4: Register 0 always reads as zero. A write to it has no effect.
- R5: Load (opcode 0x23) reads at byte address rs + sign-extended immediate and writes the data to rt. `dmem_re` is high in the 4th cycle, with `dmem_addr` equal to byte address bits [DMEM_AW+1:2]. The load takes 5 cycles.
- R6: Store (opcode 0x2B) writes the rt value to address rs + sign-extended immediate. `dmem_we` is high only in its 4th cycle, which is also its retire cycle. The store takes 4 cycles.
- R7: Branch-equal (0x04) and branch-not-equal (0x05) compare rs with rt. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate, taken as a byte offset. Otherwise the next PC is PC+4. A branch takes 4 cycles.
- R8: Jump (0x02) moves to bits [31:28] of PC+4, followed by bits [25:0] of the instruction, followed by two zero bits. It takes 4 cycles.
- R9: Jump-and-link (0x03) jumps to the same target as R8 and writes PC+4 to register 31. It takes 5 cycles.
- R10: `retire` is a single-cycle pulse in the last cycle of each instruction, and `retire_cycles` then holds that instruction's cycle count. `imem_addr` (PC bits [IMEM_AW+1:2]) changes only in the cycle after a retire, and it then points at the next instruction.
- R11: Any other opcode, or opcode 0x00 with a funct code not listed in R2, changes no register and no memory, continues at PC+4 and takes 4 cycles.
- R12: `dmem_we` and `dmem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | IMEM_AW | Instruction word address (PC bits [IMEM_AW+1:2]) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | DMEM_AW | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| retire | output | 1 | Last cycle of an instruction |
| retire_cycles | output | 3 | Cycles taken by the retiring instruction |

## Verification
The assertions check the cycle-level sequencing rules on every cycle. The read and write strobes never overlap. A store's write strobe coincides with a 4-cycle retire, and a load's read strobe is followed by a 5-cycle retire. Retire pulses never come back to back, and the fetch address holds until a retire has occurred. The bench's scenarios are the only way to show the architectural results: the ALU values, sign extension, the register-0 rule, branch and jump targets, link values and load data. For these, a reference model in the bench runs a directed prologue and then random code, and compares every retire, every store and the next fetch address against that model.

// File: rtl/seq_pkg.sv
// Package seq_pkg
// Holds the opcode and funct encodings, the step and class enumerations,
// and the decode helpers that the sequencer modules share.
// Assumes a fixed 32-bit word with 5-bit register indices.
package seq_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int CYCW = 3;
    localparam logic [RIDX-1:0] LINK_REG = 5'd31;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_J     = 6'h02;
    localparam logic [5:0] OPC_JAL   = 6'h03;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        STEP_FETCH,
        STEP_DECODE,
        STEP_EXEC,
        STEP_MEM,
        STEP_WB
    } step_t;

    typedef enum logic [2:0] {
        CLS_RALU,
        CLS_IALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_LINK,
        CLS_NONE
    } iclass_t;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_SLT,
        ALU_SLL,
        ALU_SRL
    } alu_op_t;

    // True when a register-register funct code is implemented
    function automatic logic funct_known(input logic [5:0] fn);
        case (fn)
            FN_SLL, FN_SRL, FN_ADD, FN_SUB,
            FN_AND, FN_OR, FN_XOR, FN_SLT: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

    // Map opcode and funct to an instruction class
    function automatic iclass_t classify(input logic [5:0] opc, input logic [5:0] fn);
        case (opc)
            OPC_RTYPE: return funct_known(fn) ? CLS_RALU : CLS_NONE;
            OPC_ADDI, OPC_SLTI, OPC_ANDI,
            OPC_ORI, OPC_XORI:  return CLS_IALU;
            OPC_LW:             return CLS_LOAD;
            OPC_SW:             return CLS_STORE;
            OPC_BEQ, OPC_BNE:   return CLS_BRANCH;
            OPC_J:              return CLS_JUMP;
            OPC_JAL:            return CLS_LINK;
            default:            return CLS_NONE;
        endcase
    endfunction

    // Pick the ALU operation; address and branch arithmetic use add
    function automatic alu_op_t pick_op(input logic [5:0] opc, input logic [5:0] fn);
        if (opc == OPC_RTYPE) begin
            case (fn)
                FN_SUB:  return ALU_SUB;
                FN_AND:  return ALU_AND;
                FN_OR:   return ALU_OR;
                FN_XOR:  return ALU_XOR;
                FN_SLT:  return ALU_SLT;
                FN_SLL:  return ALU_SLL;
                FN_SRL:  return ALU_SRL;
                default: return ALU_ADD;
            endcase
        end
        case (opc)
            OPC_SLTI: return ALU_SLT;
            OPC_ANDI: return ALU_AND;
            OPC_ORI:  return ALU_OR;
            OPC_XORI: return ALU_XOR;
            default:  return ALU_ADD;
        endcase
    endfunction

    // Classes that continue into the write-back step
    function automatic logic needs_writeback(input iclass_t c);
        return (c == CLS_RALU) || (c == CLS_IALU) || (c == CLS_LOAD) || (c == CLS_LINK);
    endfunction

endpackage

// File: rtl/seq_regfile.sv
// Module seq_regfile
// Register file with two combinational read ports and one synchronous
// write port. Entry 0 is hard-wired to zero and ignores writes.
// Assumes the synchronous active-low reset clears every entry.
module seq_regfile #(
    parameter int XW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [XW-1:0] rd_data_a,
    output logic [XW-1:0] rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [XW-1:0] wr_data
);

    localparam int NREG = 1 << AW;

    logic [XW-1:0] regs_q [NREG];

    // Entries 1..NREG-1 are storage; entry 0 stays a constant zero
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_entry
            if (g == 0) begin : g_zero
                assign regs_q[g] = '0;
            end else begin : g_store
                // Clear on reset, load on an addressed write
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs_q[g] <= '0;
                    end else if (wr_en && (wr_addr == AW'(g))) begin
                        regs_q[g] <= wr_data;
                    end
                end
            end
        end
    endgenerate

    // Read both ports without a clock
    always_comb begin
        rd_data_a = regs_q[rd_addr_a];
        rd_data_b = regs_q[rd_addr_b];
    end

endmodule

// File: rtl/seq_alu.sv
// Module seq_alu
// Combinational ALU shared by the register, immediate, address and branch
// target computations. Shifts act on operand y by the shamt input.
// Assumes set-less-than compares signed values.
module seq_alu
    import seq_pkg::*;
#(
    parameter int XW = 32
) (
    input  alu_op_t       op,
    input  logic [XW-1:0] x,
    input  logic [XW-1:0] y,
    input  logic [4:0]    shamt,
    output logic [XW-1:0] result
);

    // Select one operation result
    always_comb begin
        case (op)
            ALU_ADD: result = x + y;
            ALU_SUB: result = x - y;
            ALU_AND: result = x & y;
            ALU_OR:  result = x | y;
            ALU_XOR: result = x ^ y;
            ALU_SLT: result = {{(XW-1){1'b0}}, ($signed(x) < $signed(y))};
            ALU_SLL: result = y << shamt;
            ALU_SRL: result = y >> shamt;
            default: result = x + y;
        endcase
    end

endmodule

// File: rtl/seq_ctrl.sv
// Module seq_ctrl
// Step sequencer: walks fetch, decode, execute, memory and, for classes
// that write a register, write-back. It marks the retire cycle and counts
// the cycles of the current instruction.
// Assumes the class input is valid from the decode step onward.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  iclass_t       iclass,
    output step_t         step,
    output logic          retire,
    output logic [CW-1:0] cyc
);

    step_t         step_q;
    step_t         step_d;
    logic [CW-1:0] cyc_q;
    logic          last_step;

    // The last step is write-back, or memory for classes that do not write back
    always_comb begin
        last_step = (step_q == STEP_WB) ||
                    ((step_q == STEP_MEM) && !needs_writeback(iclass));
    end

    // Choose the following step
    always_comb begin
        case (step_q)
            STEP_FETCH:  step_d = STEP_DECODE;
            STEP_DECODE: step_d = STEP_EXEC;
            STEP_EXEC:   step_d = STEP_MEM;
            STEP_MEM:    step_d = needs_writeback(iclass) ? STEP_WB : STEP_FETCH;
            default:     step_d = STEP_FETCH;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_FETCH;
        end else begin
            step_q <= step_d;
        end
    end

    // Cycle counter: 1 in fetch, restarts after every retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CW'(1);
        end else if (last_step) begin
            cyc_q <= CW'(1);
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end

    assign step   = step_q;
    assign retire = last_step && rst_n;
    assign cyc    = cyc_q;

endmodule

// File: rtl/seq_core.sv
// Module seq_core
// Multi-cycle core for a 32-bit load/store subset. Intermediate values sit
// in dedicated stage registers: ir_q, npc_q, opa_q, opb_q, imm_q, res_q,
// ldata_q and cond_q. The PC advances in the retire cycle.
// Assumes both memories return data combinationally for the address driven
// in the same cycle.
module seq_core
    import seq_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [XLEN-1:0]    imem_rdata,
    output logic [DMEM_AW-1:0] dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               dmem_we,
    output logic               dmem_re,
    output logic               retire,
    output logic [CYCW-1:0]    retire_cycles
);

    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    step_t           step;
    iclass_t         iclass;
    alu_op_t         alu_op;
    logic [CYCW-1:0] cyc;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] ir_q;
    logic [XLEN-1:0] npc_q;
    logic [XLEN-1:0] opa_q;
    logic [XLEN-1:0] opb_q;
    logic [XLEN-1:0] imm_q;
    logic [XLEN-1:0] res_q;
    logic [XLEN-1:0] ldata_q;
    logic            cond_q;

    logic [5:0]      f_opc;
    logic [RIDX-1:0] f_rs;
    logic [RIDX-1:0] f_rt;
    logic [RIDX-1:0] f_rd;
    logic [4:0]      f_shamt;
    logic [5:0]      f_funct;
    logic [15:0]     f_imm;
    logic [25:0]     f_target;

    logic [XLEN-1:0] rf_a;
    logic [XLEN-1:0] rf_b;
    logic            rf_we;
    logic [RIDX-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    logic [XLEN-1:0] alu_x;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] alu_out;
    logic [XLEN-1:0] exec_val;
    logic            exec_cond;
    logic            redirect;

    // Split the held instruction word into its fields
    always_comb begin
        f_opc    = ir_q[31:26];
        f_rs     = ir_q[25:21];
        f_rt     = ir_q[20:16];
        f_rd     = ir_q[15:11];
        f_shamt  = ir_q[10:6];
        f_funct  = ir_q[5:0];
        f_imm    = ir_q[15:0];
        f_target = ir_q[25:0];
    end

    // Decode the class and ALU operation from the held word
    always_comb begin
        iclass = classify(f_opc, f_funct);
        alu_op = pick_op(f_opc, f_funct);
    end

    seq_ctrl #(
        .CW (CYCW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .iclass (iclass),
        .step   (step),
        .retire (retire),
        .cyc    (cyc)
    );

    seq_regfile #(
        .XW (XLEN),
        .AW (RIDX)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (f_rs),
        .rd_addr_b (f_rt),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .wr_en     (rf_we),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata)
    );

    // ALU operands: branches add the offset to NPC, register ops use opb_q
    always_comb begin
        alu_x = (iclass == CLS_BRANCH) ? npc_q : opa_q;
        alu_y = (iclass == CLS_RALU)   ? opb_q : imm_q;
    end

    seq_alu #(
        .XW (XLEN)
    ) u_alu (
        .op     ((iclass == CLS_RALU || iclass == CLS_IALU) ? alu_op : ALU_ADD),
        .x      (alu_x),
        .y      (alu_y),
        .shamt  (f_shamt),
        .result (alu_out)
    );

    // Execute-step value: jump target for jumps, ALU output otherwise
    always_comb begin
        if (iclass == CLS_JUMP || iclass == CLS_LINK) begin
            exec_val = {npc_q[31:28], f_target, 2'b00};
        end else begin
            exec_val = alu_out;
        end
        exec_cond = (f_opc == OPC_BNE) ? (opa_q != opb_q) : (opa_q == opb_q);
    end

    // Fetch-step registers: instruction word and incremented PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            npc_q <= '0;
        end else if (step == STEP_FETCH) begin
            ir_q  <= imem_rdata;
            npc_q <= pc_q + WORD_BYTES;
        end
    end

    // Decode-step registers: source operands and sign-extended immediate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            imm_q <= '0;
        end else if (step == STEP_DECODE) begin
            opa_q <= rf_a;
            opb_q <= rf_b;
            imm_q <= {{(XLEN-16){f_imm[15]}}, f_imm};
        end
    end

    // Execute-step registers: result or address, and branch condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cond_q <= 1'b0;
        end else if (step == STEP_EXEC) begin
            res_q  <= exec_val;
            cond_q <= exec_cond;
        end
    end

    // Memory-step register: load data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldata_q <= '0;
        end else if (step == STEP_MEM && iclass == CLS_LOAD) begin
            ldata_q <= dmem_rdata;
        end
    end

    // Take the computed target for taken branches and for jumps
    always_comb begin
        redirect = ((iclass == CLS_BRANCH) && cond_q) ||
                   (iclass == CLS_JUMP) || (iclass == CLS_LINK);
    end

    // PC register: advances in the retire cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (retire) begin
            pc_q <= redirect ? res_q : npc_q;
        end
    end

    // Write-back destination and value per class
    always_comb begin
        rf_we    = (step == STEP_WB);
        rf_waddr = f_rt;
        rf_wdata = res_q;
        case (iclass)
            CLS_RALU: rf_waddr = f_rd;
            CLS_LOAD: rf_wdata = ldata_q;
            CLS_LINK: begin
                rf_waddr = LINK_REG;
                rf_wdata = npc_q;
            end
            default: ;
        endcase
    end

    // Memory-side outputs
    always_comb begin
        imem_addr     = pc_q[IMEM_AW+1:2];
        dmem_addr     = res_q[DMEM_AW+1:2];
        dmem_wdata    = opb_q;
        dmem_we       = (step == STEP_MEM) && (iclass == CLS_STORE) && rst_n;
        dmem_re       = (step == STEP_MEM) && (iclass == CLS_LOAD) && rst_n;
        retire_cycles = cyc;
    end

endmodule

// File: rtl/seq_core_chk.sv
// Module seq_core_chk
// Checker bound to seq_core; it watches only the core's ports and states
// the cycle-level sequencing rules as concurrent properties.
// Assumes the synchronous active-low reset of the core.
module seq_core_chk #(
    parameter int IMEM_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IMEM_AW-1:0] imem_addr,
    input logic               dmem_we,
    input logic               dmem_re,
    input logic               retire,
    input logic [2:0]         retire_cycles
);

    // Strobes never overlap
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    // A store writes in its own 4-cycle retire cycle
    assert_store_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (retire && retire_cycles == 3'd4));

    // A load read is followed by a 5-cycle retire
    assert_load_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> (retire && retire_cycles == 3'd5));

    // Retire is a single-cycle pulse
    assert_retire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // Fetch address holds unless a retire just happened
    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(imem_addr));

    // Retire counts are 4 or 5
    assert_retire_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (retire_cycles == 3'd4 || retire_cycles == 3'd5));

endmodule

bind seq_core seq_core_chk #(
    .IMEM_AW (IMEM_AW)
) u_seq_core_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .imem_addr     (imem_addr),
    .dmem_we       (dmem_we),
    .dmem_re       (dmem_re),
    .retire        (retire),
    .retire_cycles (retire_cycles)
);

// File: tb/test_seq_core.sv
// Bench for seq_core: a directed prologue followed by random code, checked
// at every retire against an instruction-level model held in the bench.
module test_seq_core;

    localparam int IAW      = 8;
    localparam int DAW      = 8;
    localparam int IWORDS   = 1 << IAW;
    localparam int DWORDS   = 1 << DAW;
    localparam int N_RETIRE = 3000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [IAW-1:0] imem_addr;
    logic [31:0]    imem_rdata;
    logic [DAW-1:0] dmem_addr;
    logic [31:0]    dmem_wdata;
    logic [31:0]    dmem_rdata;
    logic           dmem_we;
    logic           dmem_re;
    logic           retire;
    logic [2:0]     retire_cycles;

    logic [31:0] imem [IWORDS];
    logic [31:0] dmem [DWORDS];
    logic [31:0] mreg [32];
    logic [31:0] mpc;

    int n_checks = 0;
    int n_fail   = 0;
    logic           re_seen = 1'b0;
    logic [DAW-1:0] re_addr = '0;

    always #10 clk = ~clk;   // 50 MHz

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    seq_core #(
        .IMEM_AW (IAW),
        .DMEM_AW (DAW)
    ) i_seq_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .imem_addr     (imem_addr),
        .imem_rdata    (imem_rdata),
        .dmem_addr     (dmem_addr),
        .dmem_wdata    (dmem_wdata),
        .dmem_rdata    (dmem_rdata),
        .dmem_we       (dmem_we),
        .dmem_re       (dmem_re),
        .retire        (retire),
        .retire_cycles (retire_cycles)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                          input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                          input logic [4:0] rs, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
        return {op, tgt};
    endfunction

    function automatic logic [4:0] rreg();
        return (($urandom % 10) == 0) ? 5'd31 : 5'($urandom % 8);
    endfunction

    // Random instruction drawn from every class
    function automatic logic [31:0] gen_rand();
        logic [5:0] fns [8] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h00, 6'h02};
        logic [5:0] iops [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
        int sel = $urandom % 20;
        if (sel < 6)  return enc_r(fns[$urandom % 8], rreg(), rreg(), rreg(), 5'($urandom));
        if (sel < 10) return enc_i(iops[$urandom % 5], rreg(), rreg(), 16'($urandom));
        if (sel < 13) return enc_i(6'h23, rreg(), rreg(), 16'(($urandom % 512) - 256));
        if (sel < 16) return enc_i(6'h2B, rreg(), rreg(), 16'(($urandom % 512) - 256));
        if (sel < 18) return enc_i((($urandom % 2) == 0) ? 6'h04 : 6'h05, 5'($urandom % 4),
                                   5'($urandom % 4), 16'(((int'($urandom % 16)) - 6) * 4));
        if (sel == 18) return enc_j((($urandom % 2) == 0) ? 6'h02 : 6'h03, 26'($urandom % IWORDS));
        return (($urandom % 2) == 0) ? {6'h3F, 26'($urandom)} : enc_r(6'h3F, 5'd1, 5'd2, 5'd3, 5'd0);
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Model one instruction at its retire and compare the ports
    task automatic model_retire();
        logic [31:0] ins = imem[mpc[IAW+1:2]];
        logic [5:0]  op  = ins[31:26];
        logic [4:0]  rs  = ins[25:21];
        logic [4:0]  rt  = ins[20:16];
        logic [4:0]  rd  = ins[15:11];
        logic [4:0]  sh  = ins[10:6];
        logic [5:0]  fn  = ins[5:0];
        logic [31:0] a   = mreg[rs];
        logic [31:0] b   = mreg[rt];
        logic [31:0] im  = sx(ins[15:0]);
        logic [31:0] npc = mpc + 32'd4;
        logic [31:0] nxt = npc;
        logic [31:0] ea  = a + im;
        logic [31:0] v   = '0;
        logic [4:0]  wr  = 5'd0;
        logic        wen = 1'b0;
        int          ecyc = 4;
        string       tag  = "R11";
        logic        st  = 1'b0;

        check(imem_addr == mpc[IAW+1:2], "R10", 32'(imem_addr), 32'(mpc[IAW+1:2]));
        case (op)
            6'h00: begin
                tag = "R2"; ecyc = 5; wen = 1'b1; wr = rd;
                case (fn)
                    6'h20: v = a + b;
                    6'h22: v = a - b;
                    6'h24: v = a & b;
                    6'h25: v = a | b;
                    6'h26: v = a ^ b;
                    6'h2A: v = 32'($signed(a) < $signed(b));
                    6'h00: v = b << sh;
                    6'h02: v = b >> sh;
                    default: begin tag = "R11"; ecyc = 4; wen = 1'b0; end
                endcase
            end
            6'h08: begin tag = "R3"; ecyc = 5; wen = 1'b1; wr = rt; v = a + im; end
            6'h0A: begin tag = "R3"; ecyc = 5; wen = 1'b1; wr = rt; v = 32'($signed(a) < $signed(im)); end
            6'h0C: begin tag = "R3"; ecyc = 5; wen = 1'b1; wr = rt; v = a & im; end
            6'h0D: begin tag = "R3"; ecyc = 5; wen = 1'b1; wr = rt; v = a | im; end
            6'h0E: begin tag = "R3"; ecyc = 5; wen = 1'b1; wr = rt; v = a ^ im; end
            6'h23: begin
                tag = "R5"; ecyc = 5; wen = 1'b1; wr = rt; v = dmem[ea[DAW+1:2]];
                check(re_seen && re_addr == ea[DAW+1:2], "R5", 32'(re_addr), 32'(ea[DAW+1:2]));
            end
            6'h2B: begin tag = "R6"; st = 1'b1; end
            6'h04: begin tag = "R7"; if (a == b) nxt = npc + im; end
            6'h05: begin tag = "R7"; if (a != b) nxt = npc + im; end
            6'h02: begin tag = "R8"; nxt = {npc[31:28], ins[25:0], 2'b00}; end
            6'h03: begin
                tag = "R9"; ecyc = 5; wen = 1'b1; wr = 5'd31; v = npc;
                nxt = {npc[31:28], ins[25:0], 2'b00};
            end
            default: ;
        endcase
        re_seen = 1'b0;

        check(retire_cycles == 3'(ecyc), tag, 32'(retire_cycles), 32'(ecyc));
        if (st) begin
            check(dmem_we && dmem_addr == ea[DAW+1:2], "R6", 32'(dmem_addr), 32'(ea[DAW+1:2]));
            check(dmem_wdata == b, "R6", dmem_wdata, b);
            if (rt == 5'd0) check(dmem_wdata == 32'd0, "R4", dmem_wdata, 32'd0);
        end else begin
            check(!dmem_we, tag, 32'(dmem_we), 32'd0);
        end
        if (wen && wr != 5'd0) mreg[wr] = v;
        mpc = nxt;
    endtask

    initial begin
        int n_ret = 0;
        int idle  = 0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DWORDS; i++) dmem[i] = $urandom;
        for (int i = 0; i < IWORDS; i++) imem[i] = gen_rand();
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        mpc = '0;

        // Directed prologue
        imem[0]  = enc_i(6'h08, 5'd1, 5'd0, 16'hFFFF);        // R3 sign extension
        imem[1]  = enc_i(6'h08, 5'd0, 5'd0, 16'd7);           // R4 write to r0
        imem[2]  = enc_i(6'h2B, 5'd0, 5'd0, 16'd16);          // R4 store r0
        imem[3]  = enc_i(6'h2B, 5'd1, 5'd0, 16'd20);          // R6 store -1
        imem[4]  = enc_i(6'h0D, 5'd2, 5'd0, 16'h7FFF);
        imem[5]  = enc_r(6'h00, 5'd3, 5'd0, 5'd2, 5'd4);      // R2 shift left
        imem[6]  = enc_r(6'h22, 5'd4, 5'd0, 5'd2, 5'd0);      // R2 subtract
        imem[7]  = enc_i(6'h23, 5'd5, 5'd0, 16'd20);          // R5 load
        imem[8]  = enc_i(6'h2B, 5'd5, 5'd0, 16'd24);
        imem[9]  = enc_i(6'h04, 5'd5, 5'd1, 16'd8);           // R7 taken
        imem[10] = {6'h3F, 26'd0};
        imem[11] = {6'h3F, 26'd0};
        imem[12] = enc_i(6'h05, 5'd5, 5'd1, 16'd8);           // R7 not taken
        imem[13] = {6'h3F, 26'h3FFFFFF};                      // R11 unknown opcode
        imem[14] = enc_j(6'h03, 26'd20);                      // R9 link
        imem[20] = enc_i(6'h2B, 5'd31, 5'd0, 16'd28);         // R9 link value
        imem[21] = enc_j(6'h02, 26'd24);                      // R8 jump
        imem[24] = enc_r(6'h3F, 5'd6, 5'd1, 5'd1, 5'd0);      // R11 unknown funct

        repeat (3) begin
            @(negedge clk);
            check(!retire && !dmem_we && !dmem_re, "R1", {29'd0, retire, dmem_we, dmem_re}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(imem_addr == '0, "R1", 32'(imem_addr), 32'd0);

        while (n_ret < N_RETIRE) begin
            check(!(dmem_we && dmem_re), "R12", {30'd0, dmem_we, dmem_re}, 32'd0);
            if (dmem_re) begin
                re_seen = 1'b1;
                re_addr = dmem_addr;
            end
            if (retire) begin
                model_retire();
                n_ret++;
                idle = 0;
            end else begin
                idle++;
            end
            if (idle > 20) begin
                check(1'b0, "R10 watchdog", 32'(idle), 32'd5);
                break;
            end
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule